// File: doc/BRIEF.md
# Dual-Bank Configurable Shift Pipeline

The block holds two banks of byte-wide registers, A and B, with eight stages in each bank. A 2-bit operation input sets what happens at each rising clock edge. The banks can shift on their own as two separate 8-stage pipelines. They can also shift together as one 16-stage pipeline, in which the last A stage feeds the first B stage. The last operation code freezes every stage.

A 4-bit select input picks any one of the sixteen stages and places it on the output. This path is combinational and does not depend on the operation, so a stage can be read in the same cycle that the banks shift. An active-low enable drives the selected byte onto a three-state bus. A second output carries the same byte at all times and never floats, so logic inside the chip can use it.

Top module: `dual_bank_pipe`

## Requirements
- R1: With op = 2'b00, a rising edge loads data_in into A stage 0. Each A stage k takes the old value of A stage k-1. B stage 0 takes the old last A stage, each B stage k takes the old value of B stage k-1, and the old last B stage is lost.
- R2: With op = 2'b01, a rising edge loads data_in into B stage 0 and shifts bank B up by one stage, losing its last stage. Every A stage keeps its value.
- R3: With op = 2'b10, a rising edge loads data_in into A stage 0 and shifts bank A up by one stage, losing its last stage. Every B stage keeps its value.
- R4: With op = 2'b11, no stage changes at the rising edge.
- R5: sel_val shows stage sel of bank A when sel[3] = 0, and stage sel[2:0] of bank B when sel[3] = 1. A change of sel shows at the output with no clock delay.
- R6: When the selected stage is being written, sel_val shows its pre-edge contents until the edge and its new contents after the edge.
- R7: When oe_n = 1, bus_o is high impedance, so another driver on the same net sets its value. When oe_n = 0, bus_o drives the same byte as sel_val.
- R8: With rst = 1 at a rising edge, all sixteen stages are zero after that edge, whatever op is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every stage |
| rst | input | 1 | Synchronous active-high clear of all stages |
| op | input | 2 | Operation: 00 chained shift, 01 bank B only, 10 bank A only, 11 hold |
| data_in | input | 8 | Byte loaded into the head stage of a shifting bank |
| sel | input | 4 | Stage select: bit 3 picks the bank, bits 2:0 pick the stage |
| oe_n | input | 1 | Active-low enable for the three-state bus |
| sel_val | output | 8 | Selected stage, always driven |
| bus_o | output | 8 | Selected stage on a three-state bus |

## Verification
A wrong stage value stays hidden until the select input points at that stage. A fault in the head stage can also be seen later, one stage further along for each shift that moves it. The bench therefore compares the selected stage against a reference copy of all sixteen stages in every cycle, and sweeps the select through all codes at set points. A wrong wrap from the last A stage into B stage 0 shows up one edge after a chained shift, at select code 8. A wrong hold or bank-isolation decode shows up as a change in a stage that should have stayed the same, at the next read of that stage.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    typedef enum logic [1:0] {
        OP_CHAIN  = 2'b00,
        OP_PUSH_B = 2'b01,
        OP_PUSH_A = 2'b10,
        OP_HOLD   = 2'b11
    } dbp_op_e;

    typedef struct packed {
        logic shift_a;
        logic shift_b;
        logic chain;
    } dbp_ctl_t;

endpackage

// File: rtl/dbp_decode.sv
module dbp_decode
    import dbp_pkg::*;
(
    input  logic [1:0] op,
    output dbp_ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        unique case (dbp_op_e'(op))
            OP_CHAIN: begin
                ctl.shift_a = 1'b1;
                ctl.shift_b = 1'b1;
                ctl.chain   = 1'b1;
            end
            OP_PUSH_B: ctl.shift_b = 1'b1;
            OP_PUSH_A: ctl.shift_a = 1'b1;
            default:   ctl = '0;
        endcase
    end

endmodule

// File: rtl/dbp_bank.sv
module dbp_bank #(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 8,
    parameter bit USE_RESET = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        shift_en,
    input  logic [WIDTH-1:0]            head_in,
    output logic [DEPTH-1:0][WIDTH-1:0] stages_o
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stg;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.stg[0] = head_in;
            for (int k = 1; k < DEPTH; k++) begin
                st_d.stg[k] = st_q.stg[k-1];
            end
        end
        if (USE_RESET && rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stages_o = st_q;

    // R4: a bank that is not shifting keeps every stage
    a_r4_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(st_q));

    // R1, R2, R3: the head stage takes the input byte
    a_r1_head_load: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> st_q.stg[0] == $past(head_in));

    // R1, R2, R3: the body moves up by one stage
    a_r1_body_shift: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> st_q.stg[DEPTH-1:1] == $past(st_q.stg[DEPTH-2:0]));

endmodule

// File: rtl/dbp_outsel.sv
module dbp_outsel #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SEL_W = IDX_W + 1
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] a_stg,
    input  logic [DEPTH-1:0][WIDTH-1:0] b_stg,
    input  logic [SEL_W-1:0]            sel,
    output logic [WIDTH-1:0]            sel_val
);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = sel[IDX_W-1:0];
        sel_val = sel[SEL_W-1] ? b_stg[idx] : a_stg[idx];
    end

endmodule

// File: rtl/dual_bank_pipe.sv
module dual_bank_pipe
    import dbp_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 8,
    parameter bit USE_RESET = 1'b1,
    localparam int SEL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] data_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             oe_n,
    output logic [WIDTH-1:0] sel_val,
    output wire  [WIDTH-1:0] bus_o
);

    dbp_ctl_t                    ctl;
    logic [DEPTH-1:0][WIDTH-1:0] a_stg;
    logic [DEPTH-1:0][WIDTH-1:0] b_stg;
    logic [WIDTH-1:0]            b_head;

    dbp_decode u_decode (
        .op  (op),
        .ctl (ctl)
    );

    dbp_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .USE_RESET(USE_RESET)) u_bank_a (
        .clk      (clk),
        .rst      (rst),
        .shift_en (ctl.shift_a),
        .head_in  (data_in),
        .stages_o (a_stg)
    );

    assign b_head = ctl.chain ? a_stg[DEPTH-1] : data_in;

    dbp_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .USE_RESET(USE_RESET)) u_bank_b (
        .clk      (clk),
        .rst      (rst),
        .shift_en (ctl.shift_b),
        .head_in  (b_head),
        .stages_o (b_stg)
    );

    dbp_outsel #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_outsel (
        .a_stg   (a_stg),
        .b_stg   (b_stg),
        .sel     (sel),
        .sel_val (sel_val)
    );

    assign bus_o = oe_n ? {WIDTH{1'bz}} : sel_val;

    // R1: the last A stage wraps into B stage 0 in chained mode
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        op == OP_CHAIN |=> b_stg[0] == $past(a_stg[DEPTH-1]));

    // R2: shifting bank B alone leaves bank A untouched
    a_r2_a_untouched: assert property (@(posedge clk) disable iff (rst)
        op == OP_PUSH_B |=> $stable(a_stg));

    // R3: shifting bank A alone leaves bank B untouched
    a_r3_b_untouched: assert property (@(posedge clk) disable iff (rst)
        op == OP_PUSH_A |=> $stable(b_stg));

    // R4: under hold, a steady select gives a steady output
    a_r4_hold_out: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> ($stable(sel) ? $stable(sel_val) : 1'b1));

    generate
        if (USE_RESET) begin : g_rst_chk
            // R8: a reset edge clears both banks
            a_r8_clear: assert property (@(posedge clk)
                rst |=> (a_stg == '0 && b_stg == '0));
        end
    endgenerate

endmodule

// File: tb/tb_dual_bank_pipe.sv
module tb_dual_bank_pipe;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PULL_VAL = 8'hA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op = 2'b11;
    logic [7:0] data_in = '0;
    logic [3:0] sel = '0;
    logic       oe_n = 1'b1;
    logic       drv_en = 1'b1;
    logic [7:0] sel_val;
    wire  [7:0] bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0][7:0] model = '0;

    assign bus = drv_en ? PULL_VAL : 8'hzz;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_pipe dut (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .data_in (data_in),
        .sel     (sel),
        .oe_n    (oe_n),
        .sel_val (sel_val),
        .bus_o   (bus)
    );

    function automatic logic [15:0][7:0] next_model(
        input logic [15:0][7:0] m, input logic [1:0] o,
        input logic [7:0] d, input logic r);
        logic [15:0][7:0] n;
        n = m;
        if (r) return '0;
        if (o == 2'b00 || o == 2'b10) begin
            n[0] = d;
            for (int k = 1; k < 8; k++) n[k] = m[k-1];
        end
        if (o == 2'b00 || o == 2'b01) begin
            n[8] = (o == 2'b00) ? m[7] : d;
            for (int k = 9; k < 16; k++) n[k] = m[k-1];
        end
        return n;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic step(input string tag, input logic [1:0] o, input logic [7:0] d,
                        input logic [3:0] s, input logic n_oe, input logic r);
        @(negedge clk);
        op = o; data_in = d; sel = s; oe_n = n_oe; drv_en = n_oe; rst = r;
        #1;
        chk(tag, sel_val, model[s]);
        chk("R7", bus, n_oe ? PULL_VAL : model[s]);
        @(posedge clk);
        model = next_model(model, o, d, r);
    endtask

    task automatic sweep(input string tag);
        for (int s = 0; s < 16; s++) step(tag, 2'b11, 8'h00, 4'(s), 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        @(posedge clk);
        @(posedge clk);
        model = '0;
        // R8: stages are zero after reset
        sweep("R8");
        // R3: fill bank A only
        for (int i = 0; i < 8; i++) step("R3", 2'b10, 8'(8'h10 + i), 4'd8, 1'b0, 1'b0);
        sweep("R3");
        // R2: fill bank B only
        for (int i = 0; i < 8; i++) step("R2", 2'b01, 8'(8'h80 + i), 4'd0, 1'b0, 1'b0);
        sweep("R2");
        // R1: chained shift, wrap A7 into B0 visible at sel 8
        for (int i = 0; i < 5; i++) step("R1", 2'b00, 8'(8'hC0 + i), 4'd8, 1'b0, 1'b0);
        sweep("R1");
        // R4: hold with changing data
        for (int i = 0; i < 4; i++) step("R4", 2'b11, 8'hFF, 4'(3 * i), 1'b0, 1'b0);
        // R6: read the stage being written, before and after the edge
        step("R6", 2'b10, 8'h3C, 4'd0, 1'b0, 1'b0);
        step("R6", 2'b01, 8'h5A, 4'd0, 1'b0, 1'b0);
        step("R6", 2'b11, 8'h00, 4'd8, 1'b0, 1'b0);
        // R7: bus released while disabled
        step("R7", 2'b11, 8'h00, 4'd8, 1'b1, 1'b0);
        // R5: random mix
        for (int i = 0; i < 600; i++)
            step("R5", 2'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), 1'b0);
        // R8: reset during a chained shift
        step("R8", 2'b00, 8'h77, 4'd0, 1'b0, 1'b1);
        sweep("R8");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule